// File: doc/BRIEF.md
# USB Endpoint OUT Receive Engine

This block is the receive side of a full-speed USB device endpoint. After token decoding has matched an OUT or SETUP token to a valid endpoint, it takes one start strobe. Both token types use the same path. The engine then reads that endpoint's receive entries from a descriptor table held in 16-bit packet memory. The first entry is the word address of the receive buffer. The second entry carries a block-size flag and a block count, and these two give the buffer's capacity in bytes.

Payload bytes come from the deserializer one strobe at a time, with the CRC already stripped. The engine packs each pair of bytes into one memory word, low byte first, and counts the bytes it receives. A down-counter, loaded with the capacity, watches for a packet longer than the buffer. If the packet fits, the engine writes the received byte count back into the receive count entry and signals that the packet may be acknowledged. If the packet overruns, the engine stops writing, gives no done strobe and leaves the descriptor as it was. The surrounding core then sends no handshake.

Top module: `usb_out_rx`

## Requirements
- R1: A `rxStart` strobe given while the engine is idle reads packet memory word `TABLE_BASE + 4*ep + 2` (buffer address) in the same cycle. It reads word `TABLE_BASE + 4*ep + 3` (count entry) in the next cycle. Memory read data returns one cycle after the request.
- R2: The low `ADDR_W` bits of the buffer address word become the write pointer. The first payload word goes to that address, and each later word goes to the next higher address.
- R3: Byte 2k of a packet lands in bits 7:0 and byte 2k+1 in bits 15:8 of buffer word k. The word is written in the cycle its high byte is strobed.
- R4: When a packet has an odd length, its last word is written in the `rxEnd` cycle, with bits 15:8 set to zero.
- R5: In the count entry, bit 15 selects the block size (0 = 2 bytes, 1 = 32 bytes) and bits 14:10 give the number of blocks. The capacity is their product, so a capacity of zero is possible.
- R6: A byte strobed when the capacity is already used up raises `rxOverrun` for that cycle. That byte and every later byte are not written, and the packet ends without `rxDone` or any descriptor write.
- R7: After a packet that fits, the cycle after `rxEnd` writes the count entry. The write keeps bits 15:10 and puts the payload byte count in bits 9:0, and `rxDone` pulses in the same cycle.
- R8: The received byte count restarts at zero for every packet, whatever earlier packets left behind.
- R9: A zero-length packet writes no buffer word, and it writes back a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxStart | input | 1 | Token matched a valid endpoint; start a reception |
| epIdx | input | EP_BITS | Endpoint number of the token |
| rxByteValid | input | 1 | One payload byte is presented |
| rxByte | input | 8 | Payload byte |
| rxEnd | input | 1 | Packet ended (CRC good, payload complete) |
| memRdata | input | 16 | Packet memory read data, one cycle after the request |
| memEn | output | 1 | Packet memory access request |
| memWe | output | 1 | Write enable for the access |
| memAddr | output | ADDR_W | Packet memory word address |
| memWdata | output | 16 | Packet memory write data |
| rxDone | output | 1 | Packet stored and count written; acknowledge it |
| rxOverrun | output | 1 | Byte arrived beyond the buffer capacity |

## Verification
The bench builds the engine with its default parameters: eight endpoints, a 512-word memory and the descriptor table at word 0. This setup puts every endpoint slot and both block sizes within reach. It sweeps five allocations, namely 0, 2 and 6 bytes (2-byte blocks) and 32 and 64 bytes (32-byte blocks). For each one it sends every packet length from zero up to two bytes past the capacity. This covers empty packets, odd and even tails, the exact-fit boundary and the first and second overrun bytes.

// File: rtl/usb_out_rx_pkg.sv
package usb_out_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_ADDR,
    ST_GET_CNT,
    ST_RECV,
    ST_WRITEBACK
  } rxState_t;

  typedef struct packed {
    logic readAddrWord;
    logic readCountWord;
    logic loadPtr;
    logic loadAlloc;
    logic storeByte;
    logic flushTail;
    logic writeBack;
  } rxStrobes_t;

  // Allocation in bytes from the block-size flag and block count.
  function automatic logic [15:0] allocBytes(input logic bigBlocks, input logic [4:0] numBlocks);
    allocBytes = bigBlocks ? {6'd0, numBlocks, 5'd0} : {10'd0, numBlocks, 1'b0};
  endfunction

endpackage

// File: rtl/usb_out_rx_ctrl.sv
module usb_out_rx_ctrl
  import usb_out_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxStart,
  input  logic       rxByteValid,
  input  logic       rxEnd,
  input  logic       bufEmpty,
  input  logic       countOdd,
  output rxStrobes_t st,
  output logic       rxDone,
  output logic       rxOverrun
);

  rxState_t state, stateNext;
  logic     ovf, ovfNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ovf   <= 1'b0;
    end else begin
      state <= stateNext;
      ovf   <= ovfNext;
    end
  end

  always_comb begin
    st        = '0;
    stateNext = state;
    ovfNext   = ovf;
    rxDone    = 1'b0;
    rxOverrun = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (rxStart) begin
          st.readAddrWord = 1'b1;
          stateNext       = ST_GET_ADDR;
        end
      end
      ST_GET_ADDR: begin
        st.loadPtr       = 1'b1;
        st.readCountWord = 1'b1;
        stateNext        = ST_GET_CNT;
      end
      ST_GET_CNT: begin
        st.loadAlloc = 1'b1;
        ovfNext      = 1'b0;
        stateNext    = ST_RECV;
      end
      ST_RECV: begin
        if (rxByteValid && !ovf) begin
          if (bufEmpty) begin
            ovfNext   = 1'b1;
            rxOverrun = 1'b1;
          end else begin
            st.storeByte = 1'b1;
          end
        end else if (rxEnd) begin
          if (ovf) begin
            stateNext = ST_IDLE;
          end else begin
            st.flushTail = countOdd;
            stateNext    = ST_WRITEBACK;
          end
        end
      end
      ST_WRITEBACK: begin
        st.writeBack = 1'b1;
        rxDone       = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/usb_out_rx_datapath.sv
module usb_out_rx_datapath
  import usb_out_rx_pkg::*;
#(
  parameter int EP_BITS    = 3,
  parameter int ADDR_W     = 9,
  parameter int TABLE_BASE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobes_t         st,
  input  logic [EP_BITS-1:0] epIdx,
  input  logic [7:0]         rxByte,
  input  logic [15:0]        memRdata,
  output logic               memEn,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [15:0]        memWdata,
  output logic               bufEmpty,
  output logic               countOdd
);

  localparam int CNT_W = 10;
  localparam int HI_W  = 16 - CNT_W;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TABLE_BASE);

  logic [EP_BITS-1:0] epReg;
  logic [ADDR_W-1:0]  ptr;
  logic [CNT_W-1:0]   byteCount;
  logic [15:0]        bufCount;
  logic [7:0]         holdLow;
  logic [HI_W-1:0]    descHi;
  logic [ADDR_W-1:0]  addrEntry, countEntry;
  logic               wordWrite;

  assign addrEntry  = BASE + ADDR_W'({epIdx, 2'b10});
  assign countEntry = BASE + ADDR_W'({epReg, 2'b11});
  assign bufEmpty   = (bufCount == 16'd0);
  assign countOdd   = byteCount[0];
  assign wordWrite  = (st.storeByte && countOdd) || st.flushTail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epReg     <= '0;
      ptr       <= '0;
      byteCount <= '0;
      bufCount  <= '0;
      holdLow   <= '0;
      descHi    <= '0;
    end else begin
      if (st.readAddrWord) begin
        epReg     <= epIdx;
        byteCount <= '0;
      end
      if (st.loadPtr) ptr <= memRdata[ADDR_W-1:0];
      if (st.loadAlloc) begin
        descHi   <= memRdata[15:CNT_W];
        bufCount <= allocBytes(memRdata[15], memRdata[14:10]);
      end
      if (st.storeByte) begin
        byteCount <= byteCount + 1'b1;
        bufCount  <= bufCount - 16'd1;
        if (!countOdd) holdLow <= rxByte;
      end
      if (wordWrite) ptr <= ptr + 1'b1;
    end
  end

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memAddr  = ptr;
    memWdata = '0;
    if (st.readAddrWord) begin
      memEn   = 1'b1;
      memAddr = addrEntry;
    end else if (st.readCountWord) begin
      memEn   = 1'b1;
      memAddr = countEntry;
    end else if (st.storeByte && countOdd) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memWdata = {rxByte, holdLow};
    end else if (st.flushTail) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memWdata = {8'h00, holdLow};
    end else if (st.writeBack) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = countEntry;
      memWdata = {descHi, byteCount};
    end
  end

endmodule

// File: rtl/usb_out_rx.sv
module usb_out_rx
  import usb_out_rx_pkg::*;
#(
  parameter int EP_BITS    = 3,
  parameter int ADDR_W     = 9,
  parameter int TABLE_BASE = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxStart,
  input  logic [EP_BITS-1:0] epIdx,
  input  logic               rxByteValid,
  input  logic [7:0]         rxByte,
  input  logic               rxEnd,
  input  logic [15:0]        memRdata,
  output logic               memEn,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [15:0]        memWdata,
  output logic               rxDone,
  output logic               rxOverrun
);

  rxStrobes_t st;
  logic       bufEmpty, countOdd;

  usb_out_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxByteValid(rxByteValid),
    .rxEnd(rxEnd), .bufEmpty(bufEmpty), .countOdd(countOdd), .st(st),
    .rxDone(rxDone), .rxOverrun(rxOverrun)
  );

  usb_out_rx_datapath #(
    .EP_BITS(EP_BITS), .ADDR_W(ADDR_W), .TABLE_BASE(TABLE_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .epIdx(epIdx), .rxByte(rxByte),
    .memRdata(memRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .bufEmpty(bufEmpty), .countOdd(countOdd)
  );

endmodule

// File: rtl/usb_out_rx_checker.sv
module usb_out_rx_checker (
  input logic clk,
  input logic rstN,
  input logic rxStart,
  input logic rxEnd,
  input logic memEn,
  input logic memWe,
  input logic rxDone,
  input logic rxOverrun
);

  logic ovfSeen;

  always_ff @(posedge clk) begin
    if (!rstN)           ovfSeen <= 1'b0;
    else if (rxStart)    ovfSeen <= 1'b0;
    else if (rxOverrun)  ovfSeen <= 1'b1;
  end

  AST_START_READ_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rxStart |-> memEn && !memWe); // R1
  AST_START_READ_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    rxStart |=> memEn && !memWe); // R1
  AST_OVERRUN_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> !memWe); // R6
  AST_SILENT_AFTER_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    ovfSeen && !rxStart |-> !memWe && !rxDone && !rxOverrun); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R7
  AST_DONE_WRITES_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> memEn && memWe); // R7
  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> $past(rxEnd)); // R7

endmodule

bind usb_out_rx usb_out_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxEnd(rxEnd), .memEn(memEn),
  .memWe(memWe), .rxDone(rxDone), .rxOverrun(rxOverrun)
);

// File: tb/usb_out_rx_tb.sv
module usb_out_rx_tb;

  localparam int EP_BITS = 3;
  localparam int ADDR_W  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxStart = 1'b0;
  logic [EP_BITS-1:0] epIdx = '0;
  logic rxByteValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic rxEnd = 1'b0;
  logic [15:0] memRdata;
  logic memEn, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memWdata;
  logic rxDone, rxOverrun;

  always #2.5 clk = ~clk;

  usb_out_rx u_dut (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .epIdx(epIdx),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .rxEnd(rxEnd),
    .memRdata(memRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .rxDone(rxDone), .rxOverrun(rxOverrun)
  );

  // Packet memory model with a bench write port
  logic [15:0] mem [0:511];
  logic tbWe = 1'b0;
  logic [ADDR_W-1:0] tbAddr = '0;
  logic [15:0] tbData = '0;
  logic clrStats = 1'b0;
  logic prevStart = 1'b0;
  logic [ADDR_W-1:0] rd0 = '0, rd1 = '0;
  logic rd0En = 1'b0, rd1En = 1'b0;
  int doneCnt = 0, ovrCnt = 0, badWr = 0, dataWr = 0;

  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (memEn && memWe) mem[memAddr] <= memWdata;
    if (memEn) memRdata <= mem[memAddr];
    prevStart <= rxStart;
    if (rxStart) begin rd0 <= memAddr; rd0En <= memEn && !memWe; end
    if (prevStart) begin rd1 <= memAddr; rd1En <= memEn && !memWe; end
    if (clrStats) begin
      doneCnt <= 0; ovrCnt <= 0; badWr <= 0; dataWr <= 0;
    end else begin
      if (rxDone) doneCnt <= doneCnt + 1;
      if (rxOverrun) ovrCnt <= ovrCnt + 1;
      if (memWe && ovrCnt != 0) badWr <= badWr + 1;
      if (memWe && !rxDone) dataWr <= dataWr + 1;
    end
  end

  int total = 0, bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tbWrite(input int a, input logic [15:0] d);
    tbAddr = ADDR_W'(a); tbData = d; tbWe = 1'b1;
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  function automatic logic [7:0] pbyte(input int seed, input int i);
    return 8'((seed * 13 + i * 37 + 5) & 8'hFF);
  endfunction

  task automatic runPacket(input int ep, input logic big, input int nb, input int len, input int seed);
    int base, cap, kept, words;
    logic [15:0] cntWord, expW;
    base = 128 + 40 * ep;
    cap = big ? nb * 32 : nb * 2;
    cntWord = {big, 5'(nb), 10'h3FF};
    tbWrite(4 * ep + 2, 16'(base));
    tbWrite(4 * ep + 3, cntWord);
    for (int w = 0; w < 36; w++) tbWrite(base + w, 16'hDEAD);
    clrStats = 1'b1; @(negedge clk); clrStats = 1'b0;
    epIdx = EP_BITS'(ep); rxStart = 1'b1;
    @(negedge clk); rxStart = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      rxByte = pbyte(seed, i); rxByteValid = 1'b1;
      @(negedge clk); rxByteValid = 1'b0;
      @(negedge clk);
    end
    rxEnd = 1'b1; @(negedge clk); rxEnd = 1'b0;
    repeat (4) @(negedge clk);

    check("R1 addr-entry read", {rd0En, 23'd0, 8'(rd0)}, {1'b1, 23'd0, 8'(4 * ep + 2)});
    check("R1 count-entry read", {rd1En, 23'd0, 8'(rd1)}, {1'b1, 23'd0, 8'(4 * ep + 3)});
    kept = (len > cap) ? cap : len;
    words = (kept + 1) / 2;
    for (int w = 0; w < words; w++) begin
      expW = {(2 * w + 1 < kept) ? pbyte(seed, 2 * w + 1) : 8'h00, pbyte(seed, 2 * w)};
      if ((kept % 2) == 1 && w == words - 1)
        check("R4 odd tail word", 32'(mem[base + w]), 32'(expW));
      else
        check("R2/R3 packed word", 32'(mem[base + w]), 32'(expW));
    end
    check("R2 no write past data", 32'(mem[base + words]), 32'h0000DEAD);
    if (len > cap) begin
      check("R5/R6 overrun pulses", 32'(ovrCnt), 32'd1);
      check("R6 no done", 32'(doneCnt), 32'd0);
      check("R6 writes after overrun", 32'(badWr), 32'd0);
      check("R6 count entry kept", 32'(mem[4 * ep + 3]), 32'(cntWord));
    end else begin
      check("R5 no overrun", 32'(ovrCnt), 32'd0);
      check("R7 done pulses", 32'(doneCnt), 32'd1);
      if (len == 0) begin
        check("R9 no buffer write", 32'(dataWr), 32'd0);
        check("R9 zero count", 32'(mem[4 * ep + 3]), 32'({big, 5'(nb), 10'd0}));
      end else begin
        check("R7/R8 count write-back", 32'(mem[4 * ep + 3]), 32'({big, 5'(nb), 10'(len)}));
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cfgBig [5] = '{0, 0, 0, 1, 1};
    int cfgNb  [5] = '{0, 1, 3, 1, 2};
    int seed = 0;
    repeat (3) @(negedge clk);
    check("R1 reset idle memEn", 32'(memEn), 32'd0);
    check("R7 reset no done", 32'(rxDone), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 5; c++) begin
      int cap = cfgBig[c] != 0 ? cfgNb[c] * 32 : cfgNb[c] * 2;
      for (int len = 0; len <= cap + 2; len++) begin
        runPacket(seed % 8, cfgBig[c] != 0, cfgNb[c], len, seed);
        seed++;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule